// File: doc/BRIEF.md
# Byte-Wide Atomic Word Write Port

This block lets a CPU with a byte-wide data bus load a register twice as wide as the bus, with no moment at which the stored word holds one new half and one old half. A write to the upper-byte strobe puts the byte into a shared holding register and nothing else. A later write to the lower-byte strobe stores the whole word in a single clock edge. The lower half comes from the bus and the upper half comes from the holding register.

A double-buffer select input chooses where the word is stored. When the select is high, the word goes to a buffer register, which the surrounding logic transfers at a safe point in its own sequence. When the select is low, the word goes straight to the live register. Reads are combinational and byte by byte. They take the stored word selected by the same input and never pass through the holding register.

Top module: `wide_reg_byte_port`

## Requirements
- R1: While reset is asserted, `live_q`, `buf_q` and `rdata` are all zero, and the holding register is cleared. A lower-byte write just after reset therefore stores zero in the upper half.
- R2: A cycle with `wr_hi`=1 and `wr_lo`=0 leaves both `live_q` and `buf_q` unchanged.
- R3: With `dbuf_en`=0, a cycle with `wr_lo`=1 sets `live_q` at that clock edge to {holding byte, `wdata`}, with the upper half in bits [2*BUS_W-1:BUS_W], and leaves `buf_q` unchanged.
- R4: With `dbuf_en`=1, a cycle with `wr_lo`=1 sets `buf_q` at that clock edge to {holding byte, `wdata`} and leaves `live_q` unchanged.
- R5: A lower-byte write does not change the holding register, so several lower-byte writes in a row all reuse the same upper byte.
- R6: When `wr_hi` and `wr_lo` are both 1 in the same cycle, the stored word uses the holding byte from before that cycle. The new byte then becomes the holding byte for later writes.
- R7: `rdata` is combinational. With `rd_hi`=1 it gives bits [2*BUS_W-1:BUS_W], and with `rd_hi`=0 it gives bits [BUS_W-1:0]. The bits come from `buf_q` when `dbuf_en`=1 and from `live_q` when `dbuf_en`=0. The holding byte never appears on `rdata`.
- R8: A cycle with no write strobe leaves `live_q`, `buf_q` and the holding byte unchanged, whatever `wdata` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dbuf_en | input | 1 | 1: writes and reads use the buffer register; 0: the live register |
| wr_hi | input | 1 | Upper-byte write strobe (loads the holding register) |
| wr_lo | input | 1 | Lower-byte write strobe (stores the whole word) |
| wdata | input | BUS_W | Write data byte |
| rd_hi | input | 1 | Read byte select: 1 upper, 0 lower |
| rdata | output | BUS_W | Read data byte |
| live_q | output | 2*BUS_W | Live register, used by the compare logic |
| buf_q | output | 2*BUS_W | Buffer register, transferred by the surrounding logic |

## Verification
The bench builds the block with BUS_W=4, which makes the stored word 8 bits wide. At that width every pair of upper and lower bytes can be written in both double-buffer settings: 256 pairs per setting, each followed by a read-back of both bytes. The same small width also makes the ordering cases cheap to cover. These are repeated lower-byte writes on one held byte, simultaneous strobes, and idle cycles with noise on the data bus. In each case the expected word is built arithmetically from the bytes driven.

// File: rtl/wrbp_pkg.sv
package wrbp_pkg;
  // Where a committed word lands.
  typedef enum logic {
    TGT_LIVE = 1'b0,
    TGT_BUF  = 1'b1
  } wrbp_tgt_e;

  localparam int NUM_TGT = 2;
endpackage

// File: rtl/wrbp_rst_sync.sv
module wrbp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/wrbp_en_reg.sv
module wrbp_en_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (en) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/wrbp_rd_mux.sv
module wrbp_rd_mux #(
  parameter int BUS_W = 8
) (
  input  logic [2*BUS_W-1:0] word,
  input  logic               sel_hi,
  output logic [BUS_W-1:0]   byte_o
);
  always_comb begin
    if (sel_hi) byte_o = word[2*BUS_W-1:BUS_W];
    else        byte_o = word[BUS_W-1:0];
  end
endmodule

// File: rtl/wide_reg_byte_port.sv
module wide_reg_byte_port
  import wrbp_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int RST_STAGE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dbuf_en,
  input  logic                 wr_hi,
  input  logic                 wr_lo,
  input  logic [BUS_W-1:0]     wdata,
  input  logic                 rd_hi,
  output logic [BUS_W-1:0]     rdata,
  output logic [2*BUS_W-1:0]   live_q,
  output logic [2*BUS_W-1:0]   buf_q
);
  localparam int WORD_W = 2 * BUS_W;

  logic              rst_n_sync;
  logic [BUS_W-1:0]  hold_q;
  logic [WORD_W-1:0] commit_word;
  logic [WORD_W-1:0] tgt_q [NUM_TGT];
  logic [WORD_W-1:0] rd_word;
  wrbp_tgt_e         commit_tgt;

  wrbp_rst_sync #(.STAGES(RST_STAGE)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_sync)
  );

  // Upper byte parks here; only wr_hi changes it.
  wrbp_en_reg #(.W(BUS_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .en    (wr_hi),
    .d     (wdata),
    .q     (hold_q)
  );

  always_comb begin
    commit_tgt  = dbuf_en ? TGT_BUF : TGT_LIVE;
    // hold_q is the registered value, so a same-cycle wr_hi is not seen here.
    commit_word = {hold_q, wdata};
  end

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
    localparam wrbp_tgt_e THIS_TGT = (g == 0) ? TGT_LIVE : TGT_BUF;
    logic tgt_en;

    always_comb begin
      tgt_en = wr_lo && (commit_tgt == THIS_TGT);
    end

    wrbp_en_reg #(.W(WORD_W)) u_word (
      .clk   (clk),
      .rst_n (rst_n_sync),
      .en    (tgt_en),
      .d     (commit_word),
      .q     (tgt_q[g])
    );
  end

  always_comb begin
    live_q  = tgt_q[0];
    buf_q   = tgt_q[1];
    rd_word = dbuf_en ? buf_q : live_q;
  end

  wrbp_rd_mux #(.BUS_W(BUS_W)) u_rd_mux (
    .word   (rd_word),
    .sel_hi (rd_hi),
    .byte_o (rdata)
  );
endmodule

// File: rtl/wrbp_checker.sv
module wrbp_checker #(
  parameter int BUS_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dbuf_en,
  input logic               wr_hi,
  input logic               wr_lo,
  input logic [BUS_W-1:0]   wdata,
  input logic [BUS_W-1:0]   hold_q,
  input logic [2*BUS_W-1:0] live_q,
  input logic [2*BUS_W-1:0] buf_q
);
  a_r2_hi_leaves_targets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> ($stable(live_q) && $stable(buf_q)));

  a_r3_commit_live: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !dbuf_en) |=>
      (live_q == {$past(hold_q), $past(wdata)}) && $stable(buf_q));

  a_r4_commit_buf: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && dbuf_en) |=>
      (buf_q == {$past(hold_q), $past(wdata)}) && $stable(live_q));

  a_r5_lo_keeps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hi |=> $stable(hold_q));

  a_r6_hi_loads_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (hold_q == $past(wdata)));

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo |=> ($stable(live_q) && $stable(buf_q)));
endmodule

bind wide_reg_byte_port wrbp_checker #(.BUS_W(BUS_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_sync),
  .dbuf_en (dbuf_en),
  .wr_hi   (wr_hi),
  .wr_lo   (wr_lo),
  .wdata   (wdata),
  .hold_q  (hold_q),
  .live_q  (live_q),
  .buf_q   (buf_q)
);

// File: tb/wide_reg_byte_port_bench.sv
`timescale 1ns/1ps
module wide_reg_byte_port_bench;
  localparam int BW = 4;
  localparam int WW = 2 * BW;

  logic          clk;
  logic          rst_n;
  logic          dbuf_en;
  logic          wr_hi;
  logic          wr_lo;
  logic [BW-1:0] wdata;
  logic          rd_hi;
  logic [BW-1:0] rdata;
  logic [WW-1:0] live_q;
  logic [WW-1:0] buf_q;

  logic [WW-1:0] exp_live;
  logic [WW-1:0] exp_buf;
  logic [BW-1:0] exp_hold;

  int checks = 0;
  int errors = 0;

  wide_reg_byte_port #(.BUS_W(BW)) u_wide_reg_byte_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .dbuf_en (dbuf_en),
    .wr_hi   (wr_hi),
    .wr_lo   (wr_lo),
    .wdata   (wdata),
    .rd_hi   (rd_hi),
    .rdata   (rdata),
    .live_q  (live_q),
    .buf_q   (buf_q)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one strobe cycle, update the model at the edge, return at the next negedge.
  task automatic drive(input logic hi, input logic lo, input logic [BW-1:0] d);
    @(negedge clk);
    wr_hi = hi; wr_lo = lo; wdata = d;
    @(posedge clk);
    if (lo) begin
      if (dbuf_en) exp_buf  = {exp_hold, d};
      else         exp_live = {exp_hold, d};
    end
    if (hi) exp_hold = d;
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b0;
  endtask

  task automatic check_targets(input string req);
    check(req, live_q, exp_live);
    check(req, buf_q, exp_buf);
  endtask

  task automatic check_read(input string req);
    logic [WW-1:0] src;
    src = dbuf_en ? exp_buf : exp_live;
    rd_hi = 1'b1; #0.5;
    check(req, WW'(rdata), WW'(src[WW-1:BW]));
    rd_hi = 1'b0; #0.5;
    check(req, WW'(rdata), WW'(src[BW-1:0]));
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dbuf_en = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0;
    wdata = '0; rd_hi = 1'b0;
    exp_live = '0; exp_buf = '0; exp_hold = '0;
    repeat (3) @(negedge clk);
    // R1: cleared state under reset
    check_targets("R1");
    check_read("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: hold cleared, so first low write has zero upper half
    drive(1'b0, 1'b1, 4'h9);
    check_targets("R1");

    // R2/R3/R4/R7: exhaustive sweep in both modes
    for (int m = 0; m < 2; m++) begin
      dbuf_en = m[0];
      for (int h = 0; h < (1 << BW); h++) begin
        for (int l = 0; l < (1 << BW); l++) begin
          drive(1'b1, 1'b0, BW'(h));
          check_targets("R2");
          drive(1'b0, 1'b1, BW'(l));
          check_targets(m == 0 ? "R3" : "R4");
          check_read("R7");
        end
      end
    end

    // R7: read the live register after buffer writes
    dbuf_en = 1'b0; #0.5;
    check_read("R7");

    // R5: repeated low writes reuse the held byte
    for (int m = 0; m < 2; m++) begin
      dbuf_en = m[0];
      drive(1'b1, 1'b0, 4'hA);
      for (int l = 0; l < 5; l++) begin
        drive(1'b0, 1'b1, BW'(3 * l + 1));
        check_targets("R5");
        check(m == 0 ? "R5" : "R5", m == 0 ? live_q : buf_q, {4'hA, BW'(3 * l + 1)});
      end
    end

    // R6: simultaneous strobes use the old holding byte
    for (int m = 0; m < 2; m++) begin
      dbuf_en = m[0];
      drive(1'b1, 1'b0, 4'h3);
      drive(1'b1, 1'b1, 4'hC);
      check(m == 0 ? "R6" : "R6", m == 0 ? live_q : buf_q, 8'h3C);
      check_targets("R6");
      drive(1'b0, 1'b1, 4'h5);
      check(m == 0 ? "R6" : "R6", m == 0 ? live_q : buf_q, 8'hC5);
    end

    // R8: idle cycles with a busy data bus
    for (int i = 0; i < 16; i++) begin
      drive(1'b0, 1'b0, BW'(i));
      check_targets("R8");
    end
    dbuf_en = 1'b0;
    drive(1'b0, 1'b1, 4'h7);
    check(" R8", live_q, {exp_hold, 4'h7});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule